// File: doc/BRIEF.md
# Key-Protected User Reset Controller

This block decides what happens when an external active-low reset pin is pulled low. A single mode register holds the policy. Software changes it only by writing a fixed password byte in the upper bits of the same word. When the pin is allowed to reset, a low level starts a reset pulse on the output pin. The pulse length is a power of two in slow-clock cycles, chosen by a 4-bit length field. When the pin is not allowed to reset, its falling level is only recorded in a status bit. That status bit can raise an interrupt.

The pin passes through a two-flop synchroniser on the slow clock before the block looks at it. The reset output is held low until the length counter has run out and the synchronised pin has gone high again. Reading the status register clears the recorded event. The whole block runs on the slow clock with a synchronous active-low reset.

Top module: `urst_ctrl`

## Requirements
- R1: A write to the mode address (0) with bits [31:24] equal to 0xA5 stores bit 0 (reset enable), bit 4 (interrupt enable) and bits [11:8] (length field). Reading the mode address returns these fields at the same positions.
- R2: A write to the mode address whose bits [31:24] differ from 0xA5 leaves every stored mode field unchanged.
- R3: A read of the mode address returns 0 in bits [31:24] and in every bit outside the three stored fields.
- R4: After reset the mode register and the status register (address 1) read 0, the reset output is high and the interrupt is low.
- R5: The pin goes through two synchroniser flops. If the pin goes low with the reset enable set, the reset output falls on the third rising clock edge after the change.
- R6: With the reset enable set and the pin low for less than the pulse, the reset output stays low for exactly 2^(L+1) clock cycles, where L is the length field.
- R7: If the pin is still low when the count runs out, the reset output stays low. It rises on the third rising edge after the pin goes high.
- R8: With the reset enable clear, a low pin never drives the reset output. A high-to-low transition of the synchronised pin sets status bit 0. Holding the pin low does not set the bit again. With the reset enable set, the status bit is never set.
- R9: A read of the status address returns the current bit and clears it on that clock edge, so the next read returns 0.
- R10: The interrupt output is high exactly when the status bit is 1, the interrupt enable is 1 and the reset enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status on a status read) |
| bus_addr | input | 2 | Register address: 0 mode, 1 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pin_rst_n | input | 1 | External active-low reset pin, asynchronous |
| user_rst_n | output | 1 | Active-low user reset output |
| irq | output | 1 | Interrupt request, active high |

## Verification
The length field is swept over almost its whole range, using a one-cycle pin pulse. Each measured width must match 2^(L+1), which separates a wrong load value from a missing or extra count cycle. A long pin hold is then compared with a short one to tell the release condition apart from the counter end. Separate pin-low events with the reset enable clear tell edge detection from level detection and show how the status bit clears. Good keys and bad keys, with junk in the bits that are not stored, check the password filter and the read-back masking. The interrupt is tried in all three enable combinations while the status bit is set.

// File: rtl/urst_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the mode record for the user reset controller.
// Assumes a 32-bit register bus; bit positions are fixed by the register layout.
package urst_pkg;
    localparam int          ERSTL_W    = 4;
    localparam int          KEY_LSB    = 24;
    localparam int          KEY_W      = 8;
    localparam logic [7:0]  KEY_VALUE  = 8'hA5;
    localparam int          EN_BIT     = 0;
    localparam int          IEN_BIT    = 4;
    localparam int          LEN_LSB    = 8;
    localparam int          MODE_IDX   = 0;
    localparam int          STAT_IDX   = 1;

    typedef struct packed {
        logic [ERSTL_W-1:0] len;
        logic               irq_en;
        logic               rst_en;
    } mode_t;
endpackage

// File: rtl/urst_sync.sv
`timescale 1ns/1ps
// Module: multi-stage synchroniser for one asynchronous active-low level.
// Assumes the input is a slow level; flops reset to the inactive (high) level.
module urst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the pin level through the chain; stage 0 samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/urst_regs.sv
`timescale 1ns/1ps
// Module: key-checked mode register and clear-on-read status bit.
// Assumes single-cycle write/read strobes; read data is combinational.
module urst_regs
    import urst_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              fall_evt,
    output mode_t             mode,
    output logic              status
);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(MODE_IDX);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_IDX);

    logic key_ok;
    logic mode_wr;
    logic stat_rd;

    assign key_ok  = (wdata[KEY_LSB +: KEY_W] == KEY_VALUE);
    assign mode_wr = wr && (addr == A_MODE) && key_ok;
    assign stat_rd = rd && (addr == A_STAT);

    // Mode register: loads only on a write that carries the password.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
        end else if (mode_wr) begin
            mode.len    <= wdata[LEN_LSB +: ERSTL_W];
            mode.irq_en <= wdata[IEN_BIT];
            mode.rst_en <= wdata[EN_BIT];
        end
    end

    // Status bit: set on a pin fall while resets are disabled; a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                        status <= 1'b0;
        else if (fall_evt && !mode.rst_en) status <= 1'b1;
        else if (stat_rd)                  status <= 1'b0;
    end

    // Read mux: the key byte and unused bits always read back as zero.
    always_comb begin
        rdata = '0;
        if (addr == A_MODE) begin
            rdata[LEN_LSB +: ERSTL_W] = mode.len;
            rdata[IEN_BIT]            = mode.irq_en;
            rdata[EN_BIT]             = mode.rst_en;
        end else if (addr == A_STAT) begin
            rdata[0] = status;
        end
    end
endmodule

// File: rtl/urst_pulse.sv
`timescale 1ns/1ps
// Module: reset pulse stretcher with a power-of-two length.
// Assumes pin_hi is already synchronised; the length is sampled when the pulse starts.
module urst_pulse #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             pin_hi,
    input  logic [LEN_W-1:0] len,
    output logic             rst_out_n
);
    localparam int CNT_W = (1 << LEN_W) + 1;

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;

    // Load value 2^(len+1)-1, built as a right-shifted mask of ones.
    assign load_val = {CNT_W{1'b1}} >> (CNT_W - 1 - int'(len));

    // Start on a low pin; count down; release once at zero and the pin is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (enable && !pin_hi) begin
                busy <= 1'b1;
                cnt  <= load_val;
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else if (pin_hi) begin
            busy <= 1'b0;
        end
    end

    assign rst_out_n = ~busy;
endmodule

// File: rtl/urst_ctrl.sv
`timescale 1ns/1ps
// Module: top of the key-protected user reset controller.
// Links the pin synchroniser, the register file and the pulse stretcher,
// and gates the interrupt. Assumes every input is on, or synchronised to, clk.
module urst_ctrl
    import urst_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pin_rst_n,
    output logic              user_rst_n,
    output logic              irq
);
    logic  pin_s;
    logic  pin_s_d;
    logic  fall_evt;
    logic  status;
    mode_t mode_q;

    urst_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_rst_n),
        .q_sync  (pin_s)
    );

    // Keep the previous synchronised level so a high-to-low step can be found.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_s_d <= 1'b1;
        else        pin_s_d <= pin_s;
    end

    assign fall_evt = pin_s_d && !pin_s;

    urst_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .fall_evt (fall_evt),
        .mode     (mode_q),
        .status   (status)
    );

    urst_pulse #(.LEN_W(ERSTL_W)) i_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (mode_q.rst_en),
        .pin_hi    (pin_s),
        .len       (mode_q.len),
        .rst_out_n (user_rst_n)
    );

    // Interrupt only while the pin is not allowed to reset.
    assign irq = status && mode_q.irq_en && !mode_q.rst_en;
endmodule

// File: rtl/urst_ctrl_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for urst_ctrl, attached by bind below.
// Assumes the default 32-bit bus; the pulse width is checked with a counter.
module urst_ctrl_chk
    import urst_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              pin_rst_n,
    input logic              user_rst_n,
    input logic              irq,
    input mode_t             mode_q
);
    localparam int W_W = (1 << ERSTL_W) + 2;

    logic [W_W-1:0] low_cnt;
    logic [W_W-1:0] exp_len;

    // Count how long the output stays low; track the expected width while it is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            exp_len <= W_W'(2);
        end else if (!user_rst_n) begin
            low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
            exp_len <= W_W'(1) << (int'(mode_q.len) + 1);
        end
    end

    p_discard_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(MODE_IDX) && bus_wdata[KEY_LSB +: KEY_W] != KEY_VALUE)
        |=> $stable(mode_q));

    p_key_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(MODE_IDX)) |-> (bus_rdata[KEY_LSB +: KEY_W] == '0));

    p_sync_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(user_rst_n) |-> ($past(pin_rst_n, 3) == 1'b0));

    p_min_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(user_rst_n) |-> (low_cnt >= exp_len));

    p_no_rst_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(user_rst_n) |-> $past(mode_q.rst_en));

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.rst_en |-> !irq);
endmodule

bind urst_ctrl urst_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pin_rst_n  (pin_rst_n),
    .user_rst_n (user_rst_n),
    .irq        (irq),
    .mode_q     (mode_q)
);

// File: tb/test_urst_ctrl.sv
`timescale 1ns/1ps
// Bench: sweeps the length field and walks the mode combinations of urst_ctrl.
// Inputs change on falling edges; outputs are sampled on falling edges.
module test_urst_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pin_rst_n = 1'b1;
    logic        user_rst_n;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    urst_ctrl i_urst_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pin_rst_n  (pin_rst_n),
        .user_rst_n (user_rst_n),
        .irq        (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_mode(input logic [7:0] key, input logic [3:0] len,
                           input logic ien, input logic en);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = 2'd0;
        bus_wdata = {key, 12'hFFF, len, 3'b111, ien, 3'b111, en};
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd   = 1'b1;
        bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
        bus_addr = 2'd0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] mode_word(input logic [3:0] len, input logic ien, input logic en);
        return {20'h0, len, 3'b0, ien, 3'b0, en};
    endfunction

    // One-cycle pin pulse, then count the low cycles of the reset output.
    task automatic measure(output int width);
        int w = 0;
        @(negedge clk);
        pin_rst_n = 1'b0;
        @(negedge clk);
        pin_rst_n = 1'b1;
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk);
            if (user_rst_n == 1'b0) w++;
            else if (w > 0) break;
        end
        width = w;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int w;
        int lows;

        idle(3);
        @(negedge clk) rst_n = 1'b1;
        idle(1);

        // R4: reset state
        chk("R4 user_rst_n", {31'b0, user_rst_n}, 32'd1);
        chk("R4 irq", {31'b0, irq}, 32'd0);
        rd_reg(2'd0, v); chk("R4 mode", v, 32'd0);
        rd_reg(2'd1, v); chk("R4 status", v, 32'd0);

        // R1/R3: keyed write, read-back masks the key and junk bits
        wr_mode(8'hA5, 4'd5, 1'b1, 1'b0);
        rd_reg(2'd0, v); chk("R1 mode fields", v, mode_word(4'd5, 1'b1, 1'b0));
        chk("R3 key byte zero", {24'b0, v[31:24]}, 32'd0);
        wr_mode(8'hA5, 4'd10, 1'b0, 1'b1);
        rd_reg(2'd0, v); chk("R1 mode fields 2", v, mode_word(4'd10, 1'b0, 1'b1));

        // R2: bad keys discard the whole write
        wr_mode(8'h5A, 4'd3, 1'b1, 1'b0);
        rd_reg(2'd0, v); chk("R2 key 5A", v, mode_word(4'd10, 1'b0, 1'b1));
        wr_mode(8'hA4, 4'd0, 1'b1, 1'b0);
        rd_reg(2'd0, v); chk("R2 key A4", v, mode_word(4'd10, 1'b0, 1'b1));
        wr_mode(8'h00, 4'd1, 1'b0, 1'b0);
        rd_reg(2'd0, v); chk("R2 key 00", v, mode_word(4'd10, 1'b0, 1'b1));

        // R8/R9/R10: resets off, interrupt on
        wr_mode(8'hA5, 4'd0, 1'b1, 1'b0);
        @(negedge clk) pin_rst_n = 1'b0;
        lows = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!user_rst_n) lows++;
        end
        chk("R8 no reset when disabled", lows, 0);
        chk("R10 irq on", {31'b0, irq}, 32'd1);
        rd_reg(2'd1, v); chk("R8 status set", v, 32'd1);
        rd_reg(2'd1, v); chk("R9 status cleared", v, 32'd0);
        chk("R10 irq off after clear", {31'b0, irq}, 32'd0);
        idle(6);
        rd_reg(2'd1, v); chk("R8 held low no re-set", v, 32'd0);
        @(negedge clk) pin_rst_n = 1'b1;
        idle(5);

        // R10: interrupt enable clear masks a set status
        wr_mode(8'hA5, 4'd0, 1'b0, 1'b0);
        @(negedge clk) pin_rst_n = 1'b0;
        @(negedge clk) pin_rst_n = 1'b1;
        idle(5);
        chk("R10 irq masked by enable", {31'b0, irq}, 32'd0);
        wr_mode(8'hA5, 4'd0, 1'b1, 1'b0);
        chk("R10 irq when enabled", {31'b0, irq}, 32'd1);
        wr_mode(8'hA5, 4'd0, 1'b1, 1'b1);
        chk("R10 irq off with reset enable", {31'b0, irq}, 32'd0);
        rd_reg(2'd1, v); chk("R9 status kept until read", v, 32'd1);
        rd_reg(2'd1, v); chk("R9 status read clears", v, 32'd0);

        // R5: two-flop latency, output falls on the third edge
        wr_mode(8'hA5, 4'd3, 1'b0, 1'b1);
        @(negedge clk) pin_rst_n = 1'b0;
        @(negedge clk);
        chk("R5 high after edge 1", {31'b0, user_rst_n}, 32'd1);
        @(negedge clk);
        chk("R5 high after edge 2", {31'b0, user_rst_n}, 32'd1);
        @(negedge clk);
        chk("R5 low after edge 3", {31'b0, user_rst_n}, 32'd0);
        pin_rst_n = 1'b1;
        idle(30);
        chk("R5 released", {31'b0, user_rst_n}, 32'd1);
        rd_reg(2'd1, v); chk("R8 no status when enabled", v, 32'd0);

        // R6: width sweep over the length field
        for (int e = 0; e < 16; e++) begin
            if (e == 14) continue;
            wr_mode(8'hA5, 4'(e), 1'b0, 1'b1);
            measure(w);
            chk($sformatf("R6 width len=%0d", e), w, 32'd1 << (e + 1));
            idle(3);
        end

        // R7: pin held past the count keeps the output low
        wr_mode(8'hA5, 4'd0, 1'b0, 1'b1);
        @(negedge clk) pin_rst_n = 1'b0;
        idle(20);
        chk("R7 low while pin held", {31'b0, user_rst_n}, 32'd0);
        pin_rst_n = 1'b1;
        @(negedge clk);
        chk("R7 low after release edge 1", {31'b0, user_rst_n}, 32'd0);
        @(negedge clk);
        chk("R7 low after release edge 2", {31'b0, user_rst_n}, 32'd0);
        @(negedge clk);
        chk("R7 high after release edge 3", {31'b0, user_rst_n}, 32'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule